// File: doc/BRIEF.md
# Host Indirect Memory Access Port

This block gives an external host, whose data path is either 8 or 16 bits wide, a window into local memory. The host sees four 16-bit registers: two halves of a 32-bit bit-address pointer, one data register and one control register. Each register can be accessed one byte lane at a time. Certain byte accesses start a single 16-bit cycle on a simple local request/acknowledge port. A read cycle refills the data register from memory. A write cycle stores the data register into memory.

The pointer counts bits. Each automatic step therefore adds 16, which moves the pointer by one 16-bit word. When read stepping is enabled, the pointer advances before the refill that follows a host read of the data register. When write stepping is enabled, the pointer advances once the write has been acknowledged. A control bit sets which byte lane completes an access, so hosts that send the low byte first and hosts that send the high byte first both work. Only one local cycle is outstanding at a time, and the host is held off with a ready signal until that cycle is acknowledged.

Top module: `host_mem_port`

## Requirements
- R1: After reset, the pointer, data register and control register read as zero, `host_ready` is 1 and `mem_req` is 0.
- R2: A host write updates only the byte lanes whose strobes are set. Register select encoding: 0 = pointer bits 15:0, 1 = pointer bits 31:16, 2 = data, 3 = control. The control register is written through the lower lane only: bit 0 = byte-order select, bit 1 = read stepping, bit 2 = write stepping. Its other bits read as 0. A host read returns the whole selected register.
- R3: With the byte-order bit at 0, a local cycle starts on a host write to select 1 with the upper strobe set, or on any host access to select 2 with the upper strobe set.
- R4: With the byte-order bit at 1, a local cycle starts on a host write to select 0 with the lower strobe set, or on any host access to select 2 with the lower strobe set.
- R5: Any other host access starts no local cycle and leaves `host_ready` at 1.
- R6: A cycle started by a pointer write is a read at the pointer value just loaded, with no stepping. The returned word replaces the data register.
- R7: A cycle started by a data read is a refill. With read stepping at 1, the pointer gains 16 before the request is issued. With read stepping at 0, the same address is read again.
- R8: A cycle started by a data write stores the full data register (`mem_we` = 1) at the current pointer. With write stepping at 1, the pointer gains 16 after the acknowledge.
- R9: From the accepting edge until `mem_ack`, `host_ready` is 0 and `mem_req` stays 1 with a stable address and write data. Host requests are not accepted while `host_ready` is 0.
- R10: Pointer stepping wraps modulo 2^32 with no other effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Host access request, accepted when `host_ready` is 1 |
| host_sel | input | 2 | Register select (0 ptr low, 1 ptr high, 2 data, 3 control) |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_ub | input | 1 | Upper byte lane strobe |
| host_lb | input | 1 | Lower byte lane strobe |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Selected register contents |
| host_ready | output | 1 | Port can accept an access |
| mem_req | output | 1 | Local cycle request |
| mem_we | output | 1 | Local cycle is a write |
| mem_addr | output | 32 | Local bit address |
| mem_wdata | output | 16 | Local write data |
| mem_rdata | input | 16 | Local read data, valid with `mem_ack` |
| mem_ack | input | 1 | Local cycle completion |

## Verification
A wrong pointer or wrong control state shows up at the very next triggering access. In that case `mem_addr` carries the wrong word address, or no cycle appears at all, which the bench sees as an unchanged cycle count. A missing or misplaced step is exposed by the cycle after it, and also by direct pointer readback within a few host accesses. A wrong byte-lane trigger shows up in the cycle right after the accepting edge, as the wrong `host_ready` level or a stray `mem_req`. A bad refill is seen when the data register is next read back.

// File: rtl/hmp_pkg.sv
package hmp_pkg;

    localparam int ADDR_W    = 32;
    localparam int DATA_W    = 16;
    localparam int BYTE_W    = 8;
    localparam int CTRL_W    = 3;
    localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(DATA_W);

    typedef enum logic [1:0] {
        SEL_PTR_LO = 2'd0,
        SEL_PTR_HI = 2'd1,
        SEL_DATA   = 2'd2,
        SEL_CTRL   = 2'd3
    } hmp_sel_e;

    typedef struct packed {
        logic inc_wr;
        logic inc_rd;
        logic lbl;
    } hmp_ctrl_t;

    typedef struct packed {
        hmp_sel_e            sel;
        logic                wr;
        logic                ub;
        logic                lb;
        logic [DATA_W-1:0]   wdata;
    } hmp_acc_t;

    function automatic logic [DATA_W-1:0] merge_lanes(
        input logic [DATA_W-1:0] old_v,
        input logic [DATA_W-1:0] new_v,
        input logic              ub,
        input logic              lb);
        logic [DATA_W-1:0] r;
        r = old_v;
        if (ub) r[DATA_W-1:BYTE_W] = new_v[DATA_W-1:BYTE_W];
        if (lb) r[BYTE_W-1:0]      = new_v[BYTE_W-1:0];
        return r;
    endfunction

    function automatic logic starts_cycle(input logic lbl, input hmp_acc_t a);
        if (!lbl)
            return ((a.sel == SEL_PTR_HI) && a.wr && a.ub) ||
                   ((a.sel == SEL_DATA) && a.ub);
        else
            return ((a.sel == SEL_PTR_LO) && a.wr && a.lb) ||
                   ((a.sel == SEL_DATA) && a.lb);
    endfunction

endpackage

// File: rtl/hmp_decode.sv
module hmp_decode
    import hmp_pkg::*;
(
    input  logic      acc_valid,
    input  hmp_acc_t  acc,
    input  hmp_ctrl_t ctrl,
    output logic      start,
    output logic      start_wr,
    output logic      pre_inc
);
    logic is_data;

    always_comb begin
        is_data  = (acc.sel == SEL_DATA);
        start    = acc_valid && starts_cycle(ctrl.lbl, acc);
        start_wr = start && is_data && acc.wr;
        pre_inc  = start && is_data && !acc.wr && ctrl.inc_rd;
    end
endmodule

// File: rtl/hmp_regs.sv
module hmp_regs
    import hmp_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               acc_valid,
    input  hmp_acc_t           acc,
    input  logic               pre_inc,
    input  logic               post_inc,
    input  logic               rd_done,
    input  logic [DATA_W-1:0]  rd_data,
    output logic [ADDR_W-1:0]  ptr,
    output logic [DATA_W-1:0]  data,
    output hmp_ctrl_t          ctrl,
    output logic [DATA_W-1:0]  rdata
);
    localparam int HALF = ADDR_W / 2;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr  <= '0;
            data <= '0;
            ctrl <= '0;
        end else begin
            if (acc_valid && acc.wr) begin
                unique case (acc.sel)
                    SEL_PTR_LO: ptr[HALF-1:0]      <= merge_lanes(ptr[HALF-1:0], acc.wdata, acc.ub, acc.lb);
                    SEL_PTR_HI: ptr[ADDR_W-1:HALF] <= merge_lanes(ptr[ADDR_W-1:HALF], acc.wdata, acc.ub, acc.lb);
                    SEL_DATA:   data <= merge_lanes(data, acc.wdata, acc.ub, acc.lb);
                    SEL_CTRL:   if (acc.lb) ctrl <= hmp_ctrl_t'(acc.wdata[CTRL_W-1:0]);
                    default: ;
                endcase
            end
            if (pre_inc || post_inc) ptr <= ptr + ADDR_STEP;
            if (rd_done) data <= rd_data;
        end
    end

    always_comb begin
        unique case (acc.sel)
            SEL_PTR_LO: rdata = ptr[HALF-1:0];
            SEL_PTR_HI: rdata = ptr[ADDR_W-1:HALF];
            SEL_DATA:   rdata = data;
            default:    rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl};
        endcase
    end

    a_r7_pre_inc: assert property (@(posedge clk) disable iff (rst)
        pre_inc |=> ptr == $past(ptr) + ADDR_STEP);
    a_r6_refill: assert property (@(posedge clk) disable iff (rst)
        rd_done |=> data == $past(rd_data));
    a_r2_ctrl_upper_only: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc.wr && acc.sel == SEL_CTRL && !acc.lb) |=> $stable(ctrl));
endmodule

// File: rtl/hmp_cycle.sv
module hmp_cycle
    import hmp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic start_wr,
    input  logic mem_ack,
    output logic busy,
    output logic is_wr,
    output logic rd_done,
    output logic wr_done
);
    typedef enum logic [1:0] {CYC_IDLE, CYC_RD, CYC_WR} cyc_e;
    cyc_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= CYC_IDLE;
        end else begin
            unique case (state)
                CYC_IDLE: if (start) state <= start_wr ? CYC_WR : CYC_RD;
                CYC_RD, CYC_WR: if (mem_ack) state <= CYC_IDLE;
                default: state <= CYC_IDLE;
            endcase
        end
    end

    always_comb begin
        busy    = (state != CYC_IDLE);
        is_wr   = (state == CYC_WR);
        rd_done = (state == CYC_RD) && mem_ack;
        wr_done = (state == CYC_WR) && mem_ack;
    end

    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        (busy && !mem_ack) |=> busy);
    a_r9_no_start_busy: assert property (@(posedge clk) disable iff (rst)
        busy |-> !start);
    a_r9_release: assert property (@(posedge clk) disable iff (rst)
        (busy && mem_ack) |=> !busy);
endmodule

// File: rtl/host_mem_port.sv
module host_mem_port
    import hmp_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               host_req,
    input  logic [1:0]         host_sel,
    input  logic               host_wr,
    input  logic               host_ub,
    input  logic               host_lb,
    input  logic [DATA_W-1:0]  host_wdata,
    output logic [DATA_W-1:0]  host_rdata,
    output logic               host_ready,
    output logic               mem_req,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [DATA_W-1:0]  mem_wdata,
    input  logic [DATA_W-1:0]  mem_rdata,
    input  logic               mem_ack
);
    hmp_acc_t  acc;
    hmp_ctrl_t ctrl;
    logic      acc_valid, start, start_wr, pre_inc;
    logic      busy, is_wr, rd_done, wr_done, post_inc;
    logic [ADDR_W-1:0] ptr;
    logic [DATA_W-1:0] data;

    always_comb begin
        acc.sel   = hmp_sel_e'(host_sel);
        acc.wr    = host_wr;
        acc.ub    = host_ub;
        acc.lb    = host_lb;
        acc.wdata = host_wdata;
        acc_valid = host_req && !busy;
        post_inc  = wr_done && ctrl.inc_wr;
    end

    hmp_decode u_decode (
        .acc_valid(acc_valid), .acc(acc), .ctrl(ctrl),
        .start(start), .start_wr(start_wr), .pre_inc(pre_inc));

    hmp_regs u_regs (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc(acc),
        .pre_inc(pre_inc), .post_inc(post_inc), .rd_done(rd_done),
        .rd_data(mem_rdata), .ptr(ptr), .data(data), .ctrl(ctrl),
        .rdata(host_rdata));

    hmp_cycle u_cycle (
        .clk(clk), .rst(rst), .start(start), .start_wr(start_wr),
        .mem_ack(mem_ack), .busy(busy), .is_wr(is_wr),
        .rd_done(rd_done), .wr_done(wr_done));

    assign host_ready = !busy;
    assign mem_req    = busy;
    assign mem_we     = is_wr;
    assign mem_addr   = ptr;
    assign mem_wdata  = data;

    a_r9_stable_addr: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> $stable(mem_addr) && $stable(mem_wdata) && $stable(mem_we));
    a_r9_ready_after_ack: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack) |=> host_ready);
    a_r8_post_inc: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && mem_ack && ctrl.inc_wr) |=> mem_addr == $past(mem_addr) + ADDR_STEP);
    a_r5_idle_no_req: assert property (@(posedge clk) disable iff (rst)
        (host_ready && !(host_req && starts_cycle(ctrl.lbl, acc))) |=> !mem_req);
endmodule

// File: tb/host_mem_port_tb.sv
module host_mem_port_tb;
    logic        clk = 0, rst = 1;
    logic        host_req = 0, host_wr = 0, host_ub = 0, host_lb = 0;
    logic [1:0]  host_sel = 0;
    logic [15:0] host_wdata = 0, host_rdata, mem_wdata, mem_rdata;
    logic        host_ready, mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr;

    int checks = 0, failures = 0, ncyc = 0, cycles = 0;
    logic [31:0] last_addr;
    logic        last_we;
    logic [15:0] last_wd;
    logic [15:0] mem_b [256];
    logic [15:0] mem_m [256];
    logic [31:0] ptr_m;
    logic [15:0] data_m;
    logic [2:0]  ctrl_m;
    int dly;

    always #4 clk = ~clk;

    host_mem_port u_dut (
        .clk(clk), .rst(rst), .host_req(host_req), .host_sel(host_sel),
        .host_wr(host_wr), .host_ub(host_ub), .host_lb(host_lb),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_ready(host_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack));

    // local memory model with random acknowledge latency
    always @(posedge clk) begin
        if (rst) begin
            mem_ack <= 0; mem_rdata <= 0; dly <= 0;
        end else begin
            mem_ack <= 0;
            if (mem_req && !mem_ack) begin
                if (dly == 0) begin
                    mem_ack   <= 1;
                    mem_rdata <= mem_b[mem_addr[11:4]];
                    if (mem_we) mem_b[mem_addr[11:4]] <= mem_wdata;
                    ncyc      <= ncyc + 1;
                    last_addr <= mem_addr;
                    last_we   <= mem_we;
                    last_wd   <= mem_wdata;
                    dly       <= int'($urandom % 4);
                end else dly <= dly - 1;
            end
        end
    end

    function automatic logic trig(input logic [2:0] c, input logic [1:0] s,
                                  input logic w, input logic u, input logic l);
        if (!c[0]) return (s == 2'd1 && w && u) || (s == 2'd2 && u);
        else       return (s == 2'd0 && w && l) || (s == 2'd2 && l);
    endfunction

    function automatic logic [15:0] mrg(input logic [15:0] o, input logic [15:0] n,
                                        input logic u, input logic l);
        return {u ? n[15:8] : o[15:8], l ? n[7:0] : o[7:0]};
    endfunction

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic host_op(input string tag, input logic [1:0] s, input logic w,
                           input logic u, input logic l, input logic [15:0] wd);
        logic t, dw;
        logic [15:0] exp_rd, rd;
        logic [31:0] exp_addr;
        int c0;
        t  = trig(ctrl_m, s, w, u, l);
        dw = (s == 2'd2) && w;
        case (s)
            2'd0: exp_rd = ptr_m[15:0];
            2'd1: exp_rd = ptr_m[31:16];
            2'd2: exp_rd = data_m;
            default: exp_rd = {13'd0, ctrl_m};
        endcase
        while (!host_ready) @(negedge clk);
        c0 = ncyc;
        host_req = 1; host_sel = s; host_wr = w; host_ub = u; host_lb = l; host_wdata = wd;
        #1 rd = host_rdata;
        @(posedge clk);
        @(negedge clk);
        host_req = 0;
        if (!w) check(rd == exp_rd, {tag, " R2 read value"}, 32'(rd), 32'(exp_rd));
        if (t) check(!host_ready && mem_req, {tag, " R9 busy after trigger"}, 32'({host_ready, mem_req}), 32'h1);
        else   check(host_ready && !mem_req, {tag, " R5 no cycle"}, 32'({host_ready, mem_req}), 32'h2);
        while (!host_ready) @(negedge clk);
        // model update
        if (w) begin
            case (s)
                2'd0: ptr_m[15:0]  = mrg(ptr_m[15:0], wd, u, l);
                2'd1: ptr_m[31:16] = mrg(ptr_m[31:16], wd, u, l);
                2'd2: data_m       = mrg(data_m, wd, u, l);
                default: if (l) ctrl_m = wd[2:0];
            endcase
        end
        exp_addr = ptr_m;
        if (t) begin
            if (dw) begin
                mem_m[ptr_m[11:4]] = data_m;
                if (ctrl_m[2]) ptr_m = ptr_m + 32'd16;
            end else begin
                if (s == 2'd2 && ctrl_m[1]) ptr_m = ptr_m + 32'd16;
                exp_addr = ptr_m;
                data_m = mem_m[ptr_m[11:4]];
            end
        end
        check(ncyc - c0 == (t ? 1 : 0), {tag, " R3/R4 cycle count"}, 32'(ncyc - c0), t ? 32'd1 : 32'd0);
        if (t) begin
            check(last_addr == exp_addr, {tag, " R6/R7/R8 address"}, last_addr, exp_addr);
            check(last_we == dw, {tag, " R8 direction"}, 32'(last_we), 32'(dw));
            if (dw) check(last_wd == data_m, {tag, " R8 write data"}, 32'(last_wd), 32'(data_m));
        end
    endtask

    task automatic check_regs(input string tag);
        host_op({tag, " rb ptr lo"}, 2'd0, 0, 1, 1, 0);
        host_op({tag, " rb ptr hi"}, 2'd1, 0, 1, 1, 0);
        host_op({tag, " rb ctrl"},   2'd3, 0, 1, 1, 0);
        host_op({tag, " rb data"},   2'd2, 0, ctrl_m[0], !ctrl_m[0], 0);
    endtask

    initial begin
        while (1) begin
            @(posedge clk);
            cycles++;
            if (cycles >= 150000) begin
                checks++; failures++;
                $display("FAIL watchdog act=%0d exp<150000", cycles);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) begin
            mem_b[i] = 16'(i * 16'h1357) ^ 16'hA5C3;
            mem_m[i] = mem_b[i];
        end
        ptr_m = 0; data_m = 0; ctrl_m = 0;
        repeat (3) @(posedge clk);
        rst = 0;
        @(negedge clk);
        check(host_ready && !mem_req, "R1 reset outputs", 32'({host_ready, mem_req}), 32'h2);
        check_regs("R1 reset");

        // byte order 0: address load, refill with and without stepping
        host_op("R5 ptr lo load", 2'd0, 1, 1, 1, 16'h0040);
        host_op("R6 R3 ptr hi load", 2'd1, 1, 1, 1, 16'h0000);
        host_op("R7 R3 reread", 2'd2, 0, 1, 0, 0);
        host_op("R2 ctrl ub ignored", 2'd3, 1, 1, 0, 16'h0007);
        host_op("R2 ctrl set incrd", 2'd3, 1, 0, 1, 16'h0002);
        host_op("R7 pre inc", 2'd2, 0, 1, 1, 0);
        check_regs("R7 after");
        // data write, lower then upper lane, with post stepping
        host_op("R2 ctrl incwr", 2'd3, 1, 0, 1, 16'h0004);
        host_op("R5 data lb", 2'd2, 1, 0, 1, 16'h00AB);
        host_op("R8 R3 data ub", 2'd2, 1, 1, 0, 16'hCD00);
        check_regs("R8 after");
        // byte order 1
        host_op("R4 ctrl lbl", 2'd3, 1, 0, 1, 16'h0003);
        host_op("R5 ptr hi lbl1", 2'd1, 1, 1, 1, 16'h0000);
        host_op("R4 ptr lo lbl1", 2'd0, 1, 1, 1, 16'h0120);
        host_op("R5 data ub lbl1", 2'd2, 0, 1, 0, 0);
        host_op("R4 R7 data lb lbl1", 2'd2, 0, 0, 1, 0);
        host_op("R4 R8 data write lbl1", 2'd2, 1, 0, 1, 16'h1234);
        check_regs("R4 after");
        // wrap
        host_op("R10 ctrl", 2'd3, 1, 0, 1, 16'h0006);
        host_op("R10 lo", 2'd0, 1, 1, 1, 16'hFFF0);
        host_op("R10 hi", 2'd1, 1, 1, 1, 16'hFFFF);
        host_op("R10 wrap read", 2'd2, 0, 1, 0, 0);
        check_regs("R10 after read");
        host_op("R10 lo2", 2'd0, 1, 1, 1, 16'hFFF0);
        host_op("R10 hi2", 2'd1, 1, 1, 1, 16'hFFFF);
        host_op("R10 wrap write", 2'd2, 1, 1, 1, 16'h5A5A);
        check_regs("R10 after write");

        // constrained random mix
        for (int n = 0; n < 400; n++) begin
            logic [1:0] s;
            s = 2'($urandom % 4);
            host_op("RND R2 R3 R4 R7 R8", s, 1'($urandom), 1'($urandom), 1'($urandom),
                    (s == 2'd1) ? 16'($urandom % 2) : 16'($urandom));
            if (n % 5 == 4) check_regs("RND");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule